// File: doc/BRIEF.md
# Backplane Timing DPLL

This block turns a 16.384 MHz master clock into the timing set of a serial time-division backplane. It produces a 4.096 MHz clock, a 2.048 MHz clock and an active-low 8 kHz frame pulse. A single frame counter of `FRAME_LEN` master cycles (2048 by default) drives all three outputs. Each output is a registered decode of that counter.

The block has two modes. In free-run mode it only divides the master clock and pays no attention to the reference input. In locked mode it compares the falling edge of an 8 kHz reference against its own frame timing. When the phase error is inside a dead band of `DEAD_BAND` master cycles, it does nothing. Outside the dead band it slips the frame counter by one master cycle per frame until the error is back at the edge of the dead band. Small wander on the reference therefore never reaches the outputs, and the phase between reference and outputs is not fixed. A mode change takes effect only at a frame boundary. The block must be reset after power-up.

Top module: `bpTimingDpll`

## Requirements
- R1: `clk4o` has a period of 4 master cycles. It is high for the first two cycles of every group of four, counted from the frame start. The frame start is the edge two cycles after `framePulseN` falls.
- R2: `clk2o` has a period of 8 master cycles and is high for the first four cycles of every group of eight from the frame start. It changes only on an edge where `clk4o` rises.
- R3: In free-run mode, successive falls of `framePulseN` are exactly `FRAME_LEN` cycles apart. The pulse stays low for exactly four master cycles. It falls on the edge that leaves two cycles of the frame, when both clocks are low.
- R4: Free-run mode is selected when `modeSel` is 4'b1101 or 4'b1111, that is, bits 0, 2 and 3 are high and bit 1 does not matter. In free-run mode the reference has no effect on any output.
- R5: Every other `modeSel` code selects locked mode. In this mode only a falling edge of `refFrameN` is measured. Let j be the edge where `framePulseN` falls and q the first edge that samples the reference low. The phase error is e = q − j − 1, wrapped into [−FRAME_LEN/2, FRAME_LEN/2). If |e| ≤ `DEAD_BAND`, the frame length stays `FRAME_LEN`.
- R6: If e > `DEAD_BAND`, one frame is lengthened by one cycle. If e < −`DEAD_BAND`, one frame is shortened by one cycle. Repeated frame by frame, this brings e to exactly +`DEAD_BAND` or −`DEAD_BAND` and holds it there.
- R7: At most one correction happens per frame. It is applied when the frame count is `FRAME_LEN`/2, so every frame length is `FRAME_LEN`−1, `FRAME_LEN` or `FRAME_LEN`+1, and the frame pulse is never cut short.
- R8: `modeSel` is taken into account only at a frame boundary. If a correction is still pending when free-run mode takes effect, it is dropped.
- R9: Reset is synchronous and active low. During reset, `clk4o`, `clk2o` and `framePulseN` are all 1. After release, the first fall of `framePulseN` is on edge `FRAME_LEN`−10 counted from release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk16 | input | 1 | 16.384 MHz master clock |
| rstN | input | 1 | synchronous active-low reset |
| refFrameN | input | 1 | 8 kHz reference, falling edge used |
| modeSel | input | 4 | mode selection code |
| clk4o | output | 1 | 4.096 MHz backplane clock |
| clk2o | output | 1 | 2.048 MHz backplane clock |
| framePulseN | output | 1 | active-low 8 kHz frame pulse |

## Verification
Two events can meet at the same frame boundary: a mode change that takes effect there, and a slip that was scheduled from the last reference edge of the old mode. The bench provokes this in locked mode. It places the reference ten cycles early, waits until the edge has been measured, and only then selects free-run, so the pending advance straddles the boundary. Every frame after that must still be exactly `FRAME_LEN` long. The reverse case also runs: locked mode is selected just before a far-off reference edge. The bench then checks that the first shortened frame comes only after a full locked frame has measured the reference.

// File: rtl/bpTimingPkg.sv
package bpTimingPkg;

  // strobes from the phase control to the frame datapath
  typedef struct packed {
    logic hold;   // repeat the current count once (frame becomes one cycle longer)
    logic skip;   // step the count by two (frame becomes one cycle shorter)
  } slipStrobeT;

  typedef enum logic [1:0] {
    SLIP_NONE    = 2'd0,
    SLIP_RETARD  = 2'd1,
    SLIP_ADVANCE = 2'd2
  } slipReqT;

endpackage

// File: rtl/bpFrameDatapath.sv
module bpFrameDatapath
  import bpTimingPkg::*;
#(
  parameter int FRAME_LEN = 2048,   // master cycles per frame, multiple of 8, at least 32
  parameter int CNT_W     = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  slipStrobeT       strobes,
  output logic [CNT_W-1:0] frameCnt,
  output logic             frameEnd,
  output logic             clk4o,
  output logic             clk2o,
  output logic             framePulseN
);

  localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] START_CNT = CNT_W'(8);
  localparam logic [CNT_W-1:0] PULSE_LO  = CNT_W'(FRAME_LEN - 2);
  localparam logic [CNT_W-1:0] PULSE_HI  = CNT_W'(1);

  logic [CNT_W-1:0] cntNext;

  function automatic logic inPulse(input logic [CNT_W-1:0] c);
    return (c >= PULSE_LO) || (c <= PULSE_HI);
  endfunction

  always_comb begin
    if (strobes.skip) begin
      cntNext = frameCnt + CNT_W'(2);
    end else if (strobes.hold) begin
      cntNext = frameCnt;
    end else if (frameCnt == LAST_CNT) begin
      cntNext = '0;
    end else begin
      cntNext = frameCnt + CNT_W'(1);
    end
  end

  assign frameEnd = (frameCnt == LAST_CNT);

  // outputs are registered decodes of the count they will sit beside
  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameCnt    <= START_CNT;
      clk4o       <= 1'b1;
      clk2o       <= 1'b1;
      framePulseN <= 1'b1;
    end else begin
      frameCnt    <= cntNext;
      clk4o       <= ~cntNext[1];
      clk2o       <= ~cntNext[2];
      framePulseN <= ~inPulse(cntNext);
    end
  end

endmodule

// File: rtl/bpPhaseCtrl.sv
module bpPhaseCtrl
  import bpTimingPkg::*;
#(
  parameter int FRAME_LEN = 2048,
  parameter int DEAD_BAND = 4,
  parameter int CNT_W     = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refFrameN,
  input  logic [3:0]       modeSel,
  input  logic [CNT_W-1:0] frameCnt,
  input  logic             frameEnd,
  output slipStrobeT       strobes,
  output logic             freeRunActive
);

  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(FRAME_LEN / 2);
  localparam logic [CNT_W-1:0] BAND_POS = CNT_W'(DEAD_BAND);
  localparam logic [CNT_W-1:0] BAND_NEG = CNT_W'(FRAME_LEN - DEAD_BAND);
  localparam int               SYNC_LEN = 3;

  logic [SYNC_LEN-1:0] refSync;
  logic                refFall;
  logic                modeFree;
  slipReqT             pending;
  slipReqT             decision;

  // two metastability flops plus one history flop for the falling-edge detector
  always_ff @(posedge clk) begin
    if (!rstN) refSync <= '1;
    else       refSync <= {refSync[SYNC_LEN-2:0], refFrameN};
  end
  assign refFall = refSync[SYNC_LEN-1] & ~refSync[SYNC_LEN-2];

  assign modeFree = (modeSel inside {4'b1101, 4'b1111});

  // the count at detection is the phase error, read as signed around zero
  always_comb begin
    if (frameCnt > BAND_POS && frameCnt < MID_CNT) begin
      decision = SLIP_RETARD;
    end else if (frameCnt >= MID_CNT && frameCnt < BAND_NEG) begin
      decision = SLIP_ADVANCE;
    end else begin
      decision = SLIP_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freeRunActive <= modeFree;
    end else if (frameEnd) begin
      freeRunActive <= modeFree;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= SLIP_NONE;
    end else if (freeRunActive) begin
      pending <= SLIP_NONE;
    end else if (strobes.hold || strobes.skip) begin
      pending <= SLIP_NONE;
    end else if (refFall) begin
      pending <= decision;
    end
  end

  always_comb begin
    strobes.hold = !freeRunActive && (pending == SLIP_RETARD)  && (frameCnt == MID_CNT);
    strobes.skip = !freeRunActive && (pending == SLIP_ADVANCE) && (frameCnt == MID_CNT);
  end

endmodule

// File: rtl/bpTimingDpll.sv
module bpTimingDpll
  import bpTimingPkg::*;
#(
  parameter int FRAME_LEN = 2048,
  parameter int DEAD_BAND = 4
) (
  input  logic       clk16,
  input  logic       rstN,
  input  logic       refFrameN,
  input  logic [3:0] modeSel,
  output logic       clk4o,
  output logic       clk2o,
  output logic       framePulseN
);

  localparam int CNT_W = $clog2(FRAME_LEN);

  slipStrobeT       ctrlStrobes;
  logic [CNT_W-1:0] frameCnt;
  logic             frameEnd;
  logic             freeRunActive;

  bpPhaseCtrl #(
    .FRAME_LEN(FRAME_LEN),
    .DEAD_BAND(DEAD_BAND),
    .CNT_W    (CNT_W)
  ) u_ctrl (
    .clk          (clk16),
    .rstN         (rstN),
    .refFrameN    (refFrameN),
    .modeSel      (modeSel),
    .frameCnt     (frameCnt),
    .frameEnd     (frameEnd),
    .strobes      (ctrlStrobes),
    .freeRunActive(freeRunActive)
  );

  bpFrameDatapath #(
    .FRAME_LEN(FRAME_LEN),
    .CNT_W    (CNT_W)
  ) u_dp (
    .clk        (clk16),
    .rstN       (rstN),
    .strobes    (ctrlStrobes),
    .frameCnt   (frameCnt),
    .frameEnd   (frameEnd),
    .clk4o      (clk4o),
    .clk2o      (clk2o),
    .framePulseN(framePulseN)
  );

endmodule

// File: rtl/bpTimingDpllChk.sv
module bpTimingDpllChk
  import bpTimingPkg::*;
#(
  parameter int FRAME_LEN = 2048,
  parameter int CNT_W     = $clog2(FRAME_LEN)
) (
  input logic             clk,
  input logic             rstN,
  input slipStrobeT       strobes,
  input logic [CNT_W-1:0] frameCnt,
  input logic             frameEnd,
  input logic             freeRunActive,
  input logic             clk4o,
  input logic             clk2o,
  input logic             framePulseN
);

  logic slipSeen;

  always_ff @(posedge clk) begin
    if (!rstN)                           slipSeen <= 1'b0;
    else if (frameEnd)                   slipSeen <= 1'b0;
    else if (strobes.hold || strobes.skip) slipSeen <= 1'b1;
  end

  AST_ONE_SLIP_PER_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.hold || strobes.skip) |-> !slipSeen); // R7

  AST_NO_SLIP_FREE_RUN: assert property (@(posedge clk) disable iff (!rstN)
    freeRunActive |-> !(strobes.hold || strobes.skip)); // R4

  AST_MODE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(freeRunActive) |-> (frameCnt == '0)); // R8

  AST_CLK2_ON_CLK4_RISE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(clk2o) |-> $rose(clk4o)); // R2

  AST_PULSE_AT_LOW_CLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    $fell(framePulseN) |-> (!clk4o && !clk2o)); // R3

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(framePulseN) |-> (!$past(framePulseN, 4) && $past(framePulseN, 5))); // R3

endmodule

bind bpTimingDpll bpTimingDpllChk #(.FRAME_LEN(FRAME_LEN)) u_chk (
  .clk          (clk16),
  .rstN         (rstN),
  .strobes      (ctrlStrobes),
  .frameCnt     (frameCnt),
  .frameEnd     (frameEnd),
  .freeRunActive(freeRunActive),
  .clk4o        (clk4o),
  .clk2o        (clk2o),
  .framePulseN  (framePulseN)
);

// File: tb/test_bpTimingDpll.sv
module test_bpTimingDpll;

  localparam int L = 64;
  localparam int W = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       refN = 1'b1;
  logic [3:0] modeSel = 4'b1101;
  logic       clk4o, clk2o, pulseN;

  bpTimingDpll #(.FRAME_LEN(L), .DEAD_BAND(W)) i_bpTimingDpll (
    .clk16      (clk),
    .rstN       (rstN),
    .refFrameN  (refN),
    .modeSel    (modeSel),
    .clk4o      (clk4o),
    .clk2o      (clk2o),
    .framePulseN(pulseN)
  );

  always #5 clk = ~clk;

  int   cyc = 0;
  int   testsRun = 0;
  int   testsFailed = 0;
  int   lastFall = -1;
  int   prevFall = -1;
  int   fallCount = 0;
  bit   patCheck = 0;
  logic prevPulse = 1'b1;
  bit   refEn = 0;
  int   refBase = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int wrapE(input int x);
    int r;
    r = ((x % L) + L) % L;
    if (r >= L / 2) r -= L;
    return r;
  endfunction

  function automatic int phaseErr();
    return wrapE(refBase - lastFall - 1);
  endfunction

  // frame pulse tracking and free-run waveform checks
  always @(negedge clk) begin
    if (rstN) begin
      if (prevPulse && !pulseN) begin
        prevFall  = lastFall;
        lastFall  = cyc;
        fallCount = fallCount + 1;
      end
      if (patCheck && lastFall >= 0) begin
        int m, c;
        m = cyc - lastFall;
        c = (L - 2 + m) % L;
        check(clk4o == (((c >> 1) & 1) == 0), "R1", int'(clk4o), int'(((c >> 1) & 1) == 0));
        check(clk2o == (((c >> 2) & 1) == 0), "R2", int'(clk2o), int'(((c >> 2) & 1) == 0));
        check(pulseN == !(c >= L - 2 || c <= 1), "R3", int'(pulseN), int'(!(c >= L - 2 || c <= 1)));
      end
    end
    prevPulse = pulseN;
  end

  // periodic reference, low for a quarter frame from each falling edge
  always @(negedge clk) begin
    if (!refEn) begin
      refN <= 1'b1;
    end else begin
      int ph;
      ph = (((cyc + 1 - refBase) % L) + L) % L;
      refN <= (ph < L / 4) ? 1'b0 : 1'b1;
    end
  end

  always @(posedge clk) begin
    if (cyc == 150000) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic waitFall();
    int n;
    n = fallCount;
    do tick(); while (fallCount == n);
  endtask

  task automatic waitOffset(input int k);
    while (cyc - lastFall != k) tick();
  endtask

  task automatic runFrames(input int n, input int lo, input int hi, input string tag,
                           output int offCount);
    offCount = 0;
    for (int i = 0; i < n; i++) begin
      int per;
      waitFall();
      per = lastFall - prevFall;
      check(per >= lo && per <= hi, tag, per, (per < lo) ? lo : hi);
      if (per != L) offCount++;
    end
  endtask

  task automatic enableRef(input int e0);
    refEn = 0;
    waitOffset(L / 2);
    refBase = lastFall + 1 + e0;
    refEn = 1;
  endtask

  initial begin
    int n;
    int relCyc;
    repeat (3) tick();
    // R9: reset values
    check(clk4o == 1'b1, "R9", int'(clk4o), 1);
    check(clk2o == 1'b1, "R9", int'(clk2o), 1);
    check(pulseN == 1'b1, "R9", int'(pulseN), 1);
    rstN = 1'b1;
    relCyc = cyc;
    waitFall();
    check(lastFall == relCyc + L - 10, "R9", lastFall - relCyc, L - 10);

    // R1 R2 R3: free-run waveform sweep
    patCheck = 1;
    runFrames(3, L, L, "R3", n);

    // R4: bit 1 is a don't care, far reference ignored
    modeSel = 4'b1111;
    enableRef(12);
    runFrames(4, L, L, "R4", n);
    patCheck = 0;

    // R5: errors inside the dead band are left alone
    modeSel = 4'b0000;
    enableRef(3);
    runFrames(5, L, L, "R5", n);
    check(phaseErr() == 3, "R5", phaseErr(), 3);
    enableRef(-W);
    runFrames(5, L, L, "R5", n);
    check(phaseErr() == -W, "R5", phaseErr(), -W);

    // R6 R7: late reference, frames stretched one cycle at a time
    modeSel = 4'b0111;
    enableRef(10);
    runFrames(10, L, L + 1, "R7", n);
    check(n == 10 - W, "R6", n, 10 - W);
    runFrames(3, L, L, "R6", n);
    check(phaseErr() == W, "R6", phaseErr(), W);

    // R6 R7: early reference, frames shortened one cycle at a time
    modeSel = 4'b1011;
    enableRef(-10);
    runFrames(10, L - 1, L, "R7", n);
    check(n == 10 - W, "R6", n, 10 - W);
    runFrames(3, L, L, "R6", n);
    check(phaseErr() == -W, "R6", phaseErr(), -W);

    // R8: advance pending when free-run takes effect at the boundary
    enableRef(-10);
    waitOffset(L - 5);
    modeSel = 4'b1101;
    runFrames(4, L, L, "R8", n);
    check(phaseErr() == -10, "R8", phaseErr(), -10);

    // R8: locked selected just before a far edge; that edge is not used
    waitOffset(L - 12);
    modeSel = 4'b0000;
    runFrames(2, L, L, "R8", n);
    runFrames(8, L - 1, L, "R6", n);
    check(n == 10 - W, "R6", n, 10 - W);
    check(phaseErr() == -W, "R6", phaseErr(), -W);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule